// File: doc/BRIEF.md
# eMMC PHY Power Sequencer

This block is a hardware state machine that brings the calibration pads and the delay-locked loop (DLL) of an eMMC PHY out of power-down, and takes them back down. A power-on or power-off request arrives on a pair of strobes, together with the measured card-clock rate in whole MHz. The block drives the PHY control pins and watches two status pins, calibration-done and DLL-ready. When the sequence ends it reports either successful completion or one of two distinct timeout errors.

Every request starts by pulling power-down-bar and DLL enable low. A power-off request ends there. A power-on request also sets up the transmit-clock and output-tap controls. It then waits for a settle time before it releases power-down-bar, and polls for calibration-done within a short timeout. After that it programs the DLL frequency band and enables the DLL. Last, it polls for DLL lock within a much longer timeout. The lock wait is skipped when the clock rate is zero, because a DLL with no input clock never locks. All times are given in microseconds and converted to reference-clock cycles through a clock-frequency parameter.

Top module: `emmc_phy_pwrseq`

## Requirements
- R1: After synchronous reset every output is 0: control pins, frequency select, busy, done, both errors and the warning.
- R2: While not busy, a high `req_on` is accepted on a clock edge. It has priority over `req_off`. On the next cycle `busy` is 1, `pd_bar` and `dll_en` are 0, and `done`, both errors and the warning are cleared.
- R3: An accepted power-off request (req_off without req_on) drives `pd_bar` and `dll_en` low on the next cycle. One cycle later it raises `done` and drops `busy`. The tap controls are left unchanged.
- R4: An accepted power-on request sets `txclk_dly_sel`=1, `otap_en`=1 and `otap_sel`=2 on the next cycle, before `pd_bar` rises.
- R5: On power-on, `pd_bar` stays low for exactly SETTLE_US*CLK_MHZ cycles after acceptance and then rises.
- R6: After `pd_bar` rises, the block waits for the synchronized calibration-done for at most CAL_TMO_US*CLK_MHZ cycles. On timeout it sets `err_cal`, drops `busy`, and leaves `dll_en` low and `freq_sel` unchanged.
- R7: `freq_sel` is loaded only after calibration-done. Its value is the band code of the rate sampled at acceptance: 0 for 170..200, 1 for 140..169, 2 for 110..139, 3 for 80..109, 4 for 50..79, and 0 for any rate outside 50..200.
- R8: `dll_en` rises one cycle after `freq_sel` is loaded, never while `pd_bar` is low.
- R9: With a sampled rate of 0 the block sets `done` right after enabling the DLL, whatever `dll_rdy_in` does.
- R10: With a nonzero rate it waits for the synchronized DLL-ready for at most LOCK_TMO_US*CLK_MHZ cycles. It then sets `done`, or `err_lock` on timeout.
- R11: `rate_warn` is set on acceptance of a power-on whose rate is above WARN_MHZ (175). The sequence runs on as normal.
- R12: Requests that arrive while `busy` is 1 are ignored. `done`, `err_cal` and `err_lock` are mutually exclusive, are 0 while busy, and hold their value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_on | input | 1 | Power-on request strobe |
| req_off | input | 1 | Power-off request strobe |
| rate_mhz | input | RATE_W | Card-clock rate in MHz, sampled on acceptance |
| cal_done_in | input | 1 | Pad calibration finished (asynchronous) |
| dll_rdy_in | input | 1 | DLL locked (asynchronous) |
| pd_bar | output | 1 | Pad power-down-bar |
| dll_en | output | 1 | DLL enable |
| freq_sel | output | 3 | DLL frequency band code |
| txclk_dly_sel | output | 1 | Select delay-chain transmit clock |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished successfully |
| err_cal | output | 1 | Calibration-done timeout |
| err_lock | output | 1 | DLL-ready timeout |
| rate_warn | output | 1 | Rate above the supported limit |

## Verification
The bench walks every band edge (49, 50, 79, 80, 109, 110, 139, 140, 169, 170, 200, 201). A band decoder that gives an edge to the lower band, or that treats out-of-range rates as anything but code 0, shows a wrong `freq_sel` there. It also runs rate 0 with a DLL that never locks. A design that always waits for lock would end in `err_lock` instead of `done`. Runs where calibration never completes must end with `err_cal`, the DLL off and the old band code intact. Other runs inject a power-off strobe mid-sequence and count the cycles that `pd_bar` stays low, which exposes a block that restarts or aborts on a busy request, or an off-by-one settle counter.

// File: rtl/pwrseq_pkg.sv
// Shared types and the frequency-band decoder for the PHY power sequencer.
// Assumes rates are whole MHz; band edges belong to the faster band.
package pwrseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OFF_FIN,
        S_SETTLE,
        S_CAL,
        S_FREQ,
        S_DLL_ON,
        S_LOCK
    } seq_state_t;

    localparam logic [2:0] BAND_170_200 = 3'd0;
    localparam logic [2:0] BAND_140_169 = 3'd1;
    localparam logic [2:0] BAND_110_139 = 3'd2;
    localparam logic [2:0] BAND_80_109  = 3'd3;
    localparam logic [2:0] BAND_50_79   = 3'd4;

    localparam logic [3:0] OTAP_SEL_ON  = 4'd2;

    // Map a clock rate to the DLL band code; out-of-range rates give code 0.
    function automatic logic [2:0] band_code(input int unsigned mhz);
        if (mhz >= 170 && mhz <= 200)      return BAND_170_200;
        else if (mhz >= 140 && mhz < 170)  return BAND_140_169;
        else if (mhz >= 110 && mhz < 140)  return BAND_110_139;
        else if (mhz >= 80 && mhz < 110)   return BAND_80_109;
        else if (mhz >= 50 && mhz < 80)    return BAND_50_79;
        else                               return BAND_170_200;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
// Two-flop synchronizer, one chain per bit, for asynchronous status pins.
// Assumes inputs are level signals held far longer than two clock cycles.
module pwrseq_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    for (genvar g = 0; g < W; g++) begin : g_chain
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one status bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end

        assign sync_out[g] = stab_q;
    end

endmodule

// File: rtl/pwrseq_rate_class.sv
// Combinational classifier of the card-clock rate: DLL band code and
// over-limit warning. Assumes the rate is an unsigned whole number of MHz.
module pwrseq_rate_class #(
    parameter int          RATE_W   = 8,
    parameter int unsigned WARN_MHZ = 175
) (
    input  logic [RATE_W-1:0] rate_mhz,
    output logic [2:0]        band,
    output logic              warn
);

    logic [31:0] rate_ext;

    // Widen the rate so comparisons against integer limits line up.
    always_comb begin
        rate_ext = 32'(rate_mhz);
        band     = pwrseq_pkg::band_code(rate_ext);
        warn     = (rate_ext > WARN_MHZ);
    end

endmodule

// File: rtl/pwrseq_timer.sv
// Loadable down-counter used for the settle delay and both poll timeouts.
// Assumes a load always has priority over counting; it stops at zero.
module pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down from the loaded value while the sequencer is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/emmc_phy_pwrseq.sv
// eMMC PHY power sequencer top. Orders pad power-down-bar, calibration
// poll, DLL band programming, DLL enable and lock poll. Assumes one
// request strobe at a time is meaningful; requests while busy are dropped.
// Times are in microseconds and converted with CLK_MHZ.
module emmc_phy_pwrseq #(
    parameter int          RATE_W      = 8,
    parameter int unsigned CLK_MHZ     = 200,
    parameter int unsigned SETTLE_US   = 5,
    parameter int unsigned CAL_TMO_US  = 50,
    parameter int unsigned LOCK_TMO_US = 50000,
    parameter int unsigned WARN_MHZ    = 175
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_on,
    input  logic              req_off,
    input  logic [RATE_W-1:0] rate_mhz,
    input  logic              cal_done_in,
    input  logic              dll_rdy_in,
    output logic              pd_bar,
    output logic              dll_en,
    output logic [2:0]        freq_sel,
    output logic              txclk_dly_sel,
    output logic              otap_en,
    output logic [3:0]        otap_sel,
    output logic              busy,
    output logic              done,
    output logic              err_cal,
    output logic              err_lock,
    output logic              rate_warn
);
    import pwrseq_pkg::*;

    localparam int unsigned SETTLE_CYC = (SETTLE_US * CLK_MHZ > 0) ? SETTLE_US * CLK_MHZ : 1;
    localparam int unsigned CAL_CYC    = (CAL_TMO_US * CLK_MHZ > 0) ? CAL_TMO_US * CLK_MHZ : 1;
    localparam int unsigned LOCK_CYC   = (LOCK_TMO_US * CLK_MHZ > 0) ? LOCK_TMO_US * CLK_MHZ : 1;
    localparam int unsigned MAX_A      = (SETTLE_CYC > CAL_CYC) ? SETTLE_CYC : CAL_CYC;
    localparam int unsigned MAX_CYC    = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
    localparam int          CNT_W      = $clog2(MAX_CYC + 1);

    seq_state_t       state_q;
    logic [2:0]       band_q;
    logic             zero_rate_q;
    logic [2:0]       cls_band;
    logic             cls_warn;
    logic [1:0]       stat_sync;
    logic             cal_s;
    logic             rdy_s;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_run;
    logic             tmr_exp;

    // Status pins cross into the reference clock domain.
    pwrseq_sync #(.W(2)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dll_rdy_in, cal_done_in}),
        .sync_out (stat_sync)
    );
    assign cal_s = stat_sync[0];
    assign rdy_s = stat_sync[1];

    pwrseq_rate_class #(.RATE_W(RATE_W), .WARN_MHZ(WARN_MHZ)) i_class (
        .rate_mhz (rate_mhz),
        .band     (cls_band),
        .warn     (cls_warn)
    );

    // Pick which wait window the shared timer starts, if any, this cycle.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state_q == S_IDLE && req_on) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(SETTLE_CYC - 1);
        end else if (state_q == S_SETTLE && tmr_exp) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(CAL_CYC - 1);
        end else if (state_q == S_DLL_ON && !zero_rate_q) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(LOCK_CYC - 1);
        end
        tmr_run = (state_q == S_SETTLE) || (state_q == S_CAL) || (state_q == S_LOCK);
    end

    pwrseq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expired  (tmr_exp)
    );

    // Sequencer: step through the power states and drive the PHY pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= S_IDLE;
            pd_bar        <= 1'b0;
            dll_en        <= 1'b0;
            freq_sel      <= '0;
            txclk_dly_sel <= 1'b0;
            otap_en       <= 1'b0;
            otap_sel      <= '0;
            busy          <= 1'b0;
            done          <= 1'b0;
            err_cal       <= 1'b0;
            err_lock      <= 1'b0;
            rate_warn     <= 1'b0;
            band_q        <= '0;
            zero_rate_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_on) begin
                        pd_bar        <= 1'b0;
                        dll_en        <= 1'b0;
                        txclk_dly_sel <= 1'b1;
                        otap_en       <= 1'b1;
                        otap_sel      <= OTAP_SEL_ON;
                        band_q        <= cls_band;
                        zero_rate_q   <= (rate_mhz == '0);
                        rate_warn     <= cls_warn;
                        done          <= 1'b0;
                        err_cal       <= 1'b0;
                        err_lock      <= 1'b0;
                        busy          <= 1'b1;
                        state_q       <= S_SETTLE;
                    end else if (req_off) begin
                        pd_bar        <= 1'b0;
                        dll_en        <= 1'b0;
                        rate_warn     <= 1'b0;
                        done          <= 1'b0;
                        err_cal       <= 1'b0;
                        err_lock      <= 1'b0;
                        busy          <= 1'b1;
                        state_q       <= S_OFF_FIN;
                    end
                end
                S_OFF_FIN: begin
                    done    <= 1'b1;
                    busy    <= 1'b0;
                    state_q <= S_IDLE;
                end
                S_SETTLE: begin
                    if (tmr_exp) begin
                        pd_bar  <= 1'b1;
                        state_q <= S_CAL;
                    end
                end
                S_CAL: begin
                    if (cal_s) begin
                        state_q <= S_FREQ;
                    end else if (tmr_exp) begin
                        err_cal <= 1'b1;
                        busy    <= 1'b0;
                        state_q <= S_IDLE;
                    end
                end
                S_FREQ: begin
                    freq_sel <= band_q;
                    state_q  <= S_DLL_ON;
                end
                S_DLL_ON: begin
                    dll_en <= 1'b1;
                    if (zero_rate_q) begin
                        done    <= 1'b1;
                        busy    <= 1'b0;
                        state_q <= S_IDLE;
                    end else begin
                        state_q <= S_LOCK;
                    end
                end
                S_LOCK: begin
                    if (rdy_s) begin
                        done    <= 1'b1;
                        busy    <= 1'b0;
                        state_q <= S_IDLE;
                    end else if (tmr_exp) begin
                        err_lock <= 1'b1;
                        busy     <= 1'b0;
                        state_q  <= S_IDLE;
                    end
                end
                default: begin
                    busy    <= 1'b0;
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwrseq_chk.sv
// Assertion checker for the PHY power sequencer, attached by bind.
// Assumes it observes the top-level ports only.
module pwrseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_on,
    input logic       req_off,
    input logic       pd_bar,
    input logic       dll_en,
    input logic       txclk_dly_sel,
    input logic       otap_en,
    input logic [3:0] otap_sel,
    input logic       busy,
    input logic       done,
    input logic       err_cal,
    input logic       err_lock
);

    // R2
    accept_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_on) |=> (busy && !pd_bar && !dll_en && !done));

    // R3
    off_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_off && !req_on) |=> ##1 (done && !busy && !pd_bar && !dll_en));

    // R4
    taps_before_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_bar) |-> (txclk_dly_sel && otap_en && otap_sel == 4'd2));

    // R6
    cal_err_dll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_cal) |-> !dll_en);

    // R8
    dll_after_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en) |-> pd_bar);

    // R12
    result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_cal, err_lock}));

    // R12
    busy_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(done || err_cal || err_lock));

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_on && !req_off) |=> ($stable(done) && $stable(err_cal) && $stable(err_lock)));

endmodule

bind emmc_phy_pwrseq pwrseq_chk i_pwrseq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_on        (req_on),
    .req_off       (req_off),
    .pd_bar        (pd_bar),
    .dll_en        (dll_en),
    .txclk_dly_sel (txclk_dly_sel),
    .otap_en       (otap_en),
    .otap_sel      (otap_sel),
    .busy          (busy),
    .done          (done),
    .err_cal       (err_cal),
    .err_lock      (err_lock)
);

// File: tb/test_emmc_phy_pwrseq.sv
module test_emmc_phy_pwrseq;

    localparam int SETTLE_CYC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_on = 1'b0;
    logic       req_off = 1'b0;
    logic [7:0] rate_mhz = '0;
    logic       cal_done_in = 1'b0;
    logic       dll_rdy_in = 1'b0;
    logic       pd_bar, dll_en, txclk_dly_sel, otap_en, busy, done, err_cal, err_lock, rate_warn;
    logic [2:0] freq_sel;
    logic [3:0] otap_sel;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cal_dly = -1;
    int lock_dly = -1;
    int cal_cnt = 0;
    int lock_cnt = 0;
    int last_code = 0;

    always #10 clk = ~clk;

    emmc_phy_pwrseq #(
        .RATE_W(8), .CLK_MHZ(1), .SETTLE_US(5), .CAL_TMO_US(50),
        .LOCK_TMO_US(400), .WARN_MHZ(175)
    ) i_emmc_phy_pwrseq (
        .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
        .rate_mhz(rate_mhz), .cal_done_in(cal_done_in), .dll_rdy_in(dll_rdy_in),
        .pd_bar(pd_bar), .dll_en(dll_en), .freq_sel(freq_sel),
        .txclk_dly_sel(txclk_dly_sel), .otap_en(otap_en), .otap_sel(otap_sel),
        .busy(busy), .done(done), .err_cal(err_cal), .err_lock(err_lock),
        .rate_warn(rate_warn)
    );

    // PHY status model: calibration and lock follow their enables after a delay.
    always @(negedge clk) begin
        cal_cnt     <= pd_bar ? cal_cnt + 1 : 0;
        lock_cnt    <= dll_en ? lock_cnt + 1 : 0;
        cal_done_in <= pd_bar && (cal_dly >= 0) && (cal_cnt >= cal_dly);
        dll_rdy_in  <= dll_en && (lock_dly >= 0) && (lock_cnt >= lock_dly);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int exp_band(input int r);
        if (r >= 50 && r <= 79)   return 4;
        if (r >= 80 && r <= 109)  return 3;
        if (r >= 110 && r <= 139) return 2;
        if (r >= 140 && r <= 169) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic do_off();
        @(negedge clk); req_off = 1'b1;
        @(negedge clk); req_off = 1'b0;
        chk(busy && !pd_bar && !dll_en, "R3 pins low", {busy, pd_bar, dll_en}, 3'b100);
        @(negedge clk);
        chk(done && !busy && !err_cal && !err_lock, "R3 done", {done, busy, err_cal, err_lock}, 4'b1000);
        chk(txclk_dly_sel && otap_en && otap_sel == 4'd2, "R3 taps kept",
            {txclk_dly_sel, otap_en, otap_sel}, 6'b110010);
    endtask

    task automatic do_on(input int r, input int cd, input int ld, input bit poke, input bit both);
        int lowcnt = 0;
        int n = 0;
        bit seen_hi = 1'b0;
        int ed, ec, el;
        cal_dly = cd; lock_dly = ld; rate_mhz = 8'(r);
        @(negedge clk); req_on = 1'b1; req_off = both;
        @(negedge clk); req_on = 1'b0; req_off = 1'b0;
        chk(busy && !pd_bar && !dll_en && !done && !err_cal && !err_lock, "R2 accept",
            {busy, pd_bar, dll_en, done}, 4'b1000);
        chk(txclk_dly_sel && otap_en && otap_sel == 4'd2, "R4 taps",
            {txclk_dly_sel, otap_en, otap_sel}, 6'b110010);
        while (busy && n < 3000) begin
            if (!seen_hi) begin
                if (pd_bar) seen_hi = 1'b1;
                else lowcnt++;
            end
            @(negedge clk); n++;
            if (poke && n == 3) req_off = 1'b1;
            if (poke && n == 4) req_off = 1'b0;
        end
        req_off = 1'b0;
        chk(lowcnt == SETTLE_CYC, "R5 settle", lowcnt, SETTLE_CYC);
        ec = (cd < 0);
        ed = !ec && (r == 0 || ld >= 0);
        el = !ec && !ed;
        chk(done == ed[0] && err_cal == ec[0] && err_lock == el[0], "R6 R9 R10 outcome",
            {done, err_cal, err_lock}, {ed[0], ec[0], el[0]});
        chk(dll_en == !ec[0] && pd_bar, "R8 dll state", {pd_bar, dll_en}, {1'b1, !ec[0]});
        if (!ec) last_code = exp_band(r);
        chk(int'(freq_sel) == last_code, "R7 band", freq_sel, last_code);
        chk(rate_warn == (r > 175), "R11 warn", rate_warn, r > 175);
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(done == ed[0] && err_cal == ec[0] && err_lock == el[0] && pd_bar,
                "R12 ignore and hold", {pd_bar, done, err_cal, err_lock}, {1'b1, ed[0], ec[0], el[0]});
        end
    endtask

    initial begin
        int rates[16] = '{0, 49, 50, 79, 80, 109, 110, 139, 140, 169, 170, 175, 176, 200, 201, 255};
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        chk({pd_bar, dll_en, freq_sel, txclk_dly_sel, otap_en, otap_sel, busy, done,
             err_cal, err_lock, rate_warn} == '0, "R1 reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pd_bar, dll_en, busy, done, err_cal, err_lock} == '0, "R1 after reset", done, 0);

        // R2: both strobes at once, power-on wins
        do_on(100, 3, 10, 1'b0, 1'b1);
        // R3: power-off after power-on
        do_off();
        // R7: band edges
        foreach (rates[i]) do_on(rates[i], 3, 10, (i % 4) == 1, 1'b0);
        // R9: zero rate, lock never comes
        do_on(0, 4, -1, 1'b0, 1'b0);
        // R10: lock timeout
        do_on(120, 4, -1, 1'b1, 1'b0);
        // R6: calibration timeout keeps old band
        do_on(60, -1, 10, 1'b1, 1'b0);
        do_off();
        // Random mix
        for (int k = 0; k < 24; k++) begin
            int r  = $urandom_range(0, 230);
            int cd = ($urandom_range(0, 5) == 0) ? -1 : int'($urandom_range(0, 30));
            int ld = ($urandom_range(0, 5) == 0) ? -1 : int'($urandom_range(0, 300));
            do_on(r, cd, ld, $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0);
            if ($urandom_range(0, 3) == 0) do_off();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule